// File: doc/BRIEF.md
# Instruction Cache Set Parity Scrubber

This block checks the protection bits of one instruction-cache set across all of its ways. A scan starts with a start pulse that also latches the set index and decides whether data entries are checked. The block then accepts a stream of items. Each way sends one tag item: a 32-bit high tag word and a 64-bit low tag word. When data checking is on, four data items follow each tag item. A data item carries a 32-bit sideband word and two 32-bit instructions. Instruction A sits in bits 63:32 of the low bus and instruction B in bits 31:0.

The block raises two flags that stay set for the rest of the scan: one for tag parity and one for data parity. It also decodes the replacement order stored in the tag of way 0. During the scan it outputs the cache address of the item it expects next. The surrounding logic can use that address to read the arrays. When the last expected item has been taken, the block emits a one-cycle done pulse. Reading the cache arrays and refilling them are done outside this block.

Top module: `icache_parity_scrubber`

## Requirements
- R1: After reset and after a start pulse both parity flags are 0. A start pulse sets busy, latches the index and the data-check enable, and points the expected item at way 0, tag type. A start pulse during a scan restarts the scan.
- R2: In a tag item, high bit 29 is the valid bit and high bit 27 is its parity copy. If the two differ, the tag flag is raised, whether or not the way is valid.
- R3: For a valid way, low-tag bit 10 must equal the XOR of low bits 23:0 with bits 11 and 10 left out. A mismatch raises the tag flag. For an invalid way this field is not checked.
- R4: For a valid way, low-tag bit 11 must equal the XOR of low bits 63:24. A mismatch raises the tag flag. For an invalid way this field is not checked.
- R5: In a data item, sideband bits 15:8 are predecode bits and sideband bit 16 must equal their XOR. A mismatch raises the data flag.
- R6: Sideband bits 7:4 hold the even parity of the four bytes of instruction A, and bits 3:0 hold those of instruction B. Parity bit k (k from 0 to 3) covers instruction bits 8k+7:8k, so the top byte maps to the top bit. Any mismatch raises the data flag.
- R7: The order output takes high-tag bits 21:14 of the way-0 tag item. The order output is four 2-bit way numbers, from least recently used (bits 1:0) to most recently used (bits 7:6). The least-recently-used output is bits 1:0 of that field, and the most-recently-used output is bits 7:6. Tag items of other ways leave the order unchanged. A start clears it to 0.
- R8: With data checking on, each way expects one tag item followed by four data items. With it off, each way expects only a tag item. Ways are visited in order 0 to 3. In the cycle after the last expected item is taken, busy is 0 and done is 1 for exactly one cycle.
- R9: The expected address is {way[1:0], index[7:0], entry[1:0], 3'b000}: the way at bit 13, the index at bits 12:5, and the entry times 8. The next-type output is 1 when a data item is expected. The bank output is index bits 1:0 and the set output is index bits 7:2.
- R10: Once a flag is set it stays set until the next start pulse. An item whose type differs from the expected type is ignored. Items that arrive while no scan is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_start | input | 1 | Starts or restarts a set scan |
| scan_data_en | input | 1 | Data items expected after each tag (latched at start) |
| scan_index | input | 8 | Set index, address bits 12:5 (latched at start) |
| item_valid | input | 1 | An item is present this cycle |
| item_is_data | input | 1 | 0 = tag item, 1 = data item |
| item_hi | input | 32 | High tag word or data sideband word |
| item_lo | input | 64 | Low tag word or {instruction A, instruction B} |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | One-cycle pulse after the last item |
| tag_parity_err | output | 1 | Sticky tag parity flag |
| data_parity_err | output | 1 | Sticky data parity flag |
| lru_order | output | 8 | Four way numbers, LRU in bits 1:0 |
| lru_way | output | 2 | Least recently used way |
| mru_way | output | 2 | Most recently used way |
| next_addr | output | 15 | Cache address of the next expected item |
| next_is_data | output | 1 | Next expected item is a data item |
| scan_bank | output | 2 | Bank of the latched index |
| scan_set | output | 6 | Set of the latched index |

## Verification
A corrupted way or entry counter shows up at the ports right away. The expected address and type are wrong in the very next cycle, and the done pulse arrives early or late. A flag register that is cleared or set wrongly shows up in the cycle after the item that should have changed it. The bench checks the address before every item and the flags right after chosen items. Because of this, a fault is pinned to the item where it first appears, not only to the end of the scan.

// File: rtl/icps_pkg.sv
// Package: field positions of the instruction-cache tag and data words,
// plus the item type encoding shared by the scrubber modules.
// Assumes the fixed word layout listed in the brief.
package icps_pkg;
    localparam int VALID_BIT    = 29;
    localparam int VALID_PAR    = 27;
    localparam int LRU_LSB      = 14;
    localparam int TPAR_LOW     = 10;
    localparam int TPAR_HIGH    = 11;
    localparam int TAG_SPLIT    = 24;
    localparam int PRE_PAR      = 16;
    localparam int PRE_LSB      = 8;
    localparam int PRE_W        = 8;
    localparam int IPAR_A_LSB   = 4;
    localparam int IPAR_B_LSB   = 0;

    typedef enum logic {
        ITEM_TAG  = 1'b0,
        ITEM_DATA = 1'b1
    } item_kind_e;
endpackage

// File: rtl/icps_tag_check.sv
// Tag checker: combinational parity check of one way's tag word pair.
// It checks the valid-bit copy every time, and checks the two low-tag
// parity fields only when the way is valid. Assumes a 32/64-bit tag pair.
module icps_tag_check
    import icps_pkg::*;
#(
    parameter int HI_W = 32,
    parameter int LO_W = 64
) (
    input  logic [HI_W-1:0] tag_hi,
    input  logic [LO_W-1:0] tag_lo,
    output logic            tag_bad
);
    localparam int LOW_SPAN = TAG_SPLIT;

    logic              vld;
    logic              vld_bad;
    logic [LOW_SPAN-1:0] low_masked;
    logic              low_bad;
    logic              high_bad;
    logic              unused_hi;

    // Compare the valid bit with its copy, then the low-tag fields when valid.
    always_comb begin
        vld        = tag_hi[VALID_BIT];
        vld_bad    = tag_hi[VALID_BIT] ^ tag_hi[VALID_PAR];
        low_masked = tag_lo[LOW_SPAN-1:0];
        low_masked[TPAR_LOW]  = 1'b0;
        low_masked[TPAR_HIGH] = 1'b0;
        low_bad    = vld & (tag_lo[TPAR_LOW]  ^ (^low_masked));
        high_bad   = vld & (tag_lo[TPAR_HIGH] ^ (^tag_lo[LO_W-1:TAG_SPLIT]));
        tag_bad    = vld_bad | low_bad | high_bad;
    end

    assign unused_hi = ^{tag_hi[HI_W-1:VALID_BIT+1], tag_hi[VALID_BIT-1:VALID_PAR+1],
                         tag_hi[VALID_PAR-1:0]};
endmodule

// File: rtl/icps_data_check.sv
// Data checker: combinational check of one data entry. It checks the
// predecode parity and the per-byte even parity of both instructions.
// Assumes the parity nibble bit k covers byte k of its instruction.
module icps_data_check
    import icps_pkg::*;
#(
    parameter int SB_W   = 32,
    parameter int INSN_W = 32
) (
    input  logic [SB_W-1:0]   sideband,
    input  logic [INSN_W-1:0] insn_a,
    input  logic [INSN_W-1:0] insn_b,
    output logic              data_bad
);
    localparam int NBYTES = INSN_W / 8;

    logic [NBYTES-1:0] par_a;
    logic [NBYTES-1:0] par_b;
    logic              pre_bad;
    logic              unused_sb;

    // One parity bit per byte, for each instruction.
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign par_a[b] = ^insn_a[b*8 +: 8];
        assign par_b[b] = ^insn_b[b*8 +: 8];
    end

    // Combine the predecode parity with both byte-parity comparisons.
    always_comb begin
        pre_bad  = sideband[PRE_PAR] ^ (^sideband[PRE_LSB +: PRE_W]);
        data_bad = pre_bad
                 | (sideband[IPAR_A_LSB +: NBYTES] != par_a)
                 | (sideband[IPAR_B_LSB +: NBYTES] != par_b);
    end

    assign unused_sb = ^sideband[SB_W-1:PRE_PAR+1];
endmodule

// File: rtl/icps_seq.sv
// Sequencer: tracks which way, entry and item type the scan expects next.
// It ends the scan with a one-cycle done pulse. Assumes 'take' is high only
// for an accepted item of the expected type while busy.
module icps_seq #(
    parameter int NUM_WAYS = 4,
    parameter int ENTRIES  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        chk_data,
    input  logic                        take,
    output logic                        busy,
    output logic                        done,
    output logic                        phase_data,
    output logic [$clog2(NUM_WAYS)-1:0] way,
    output logic [$clog2(ENTRIES)-1:0]  ent
);
    localparam int WAY_W = $clog2(NUM_WAYS);
    localparam int ENT_W = $clog2(ENTRIES);
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);
    localparam logic [ENT_W-1:0] LAST_ENT = ENT_W'(ENTRIES - 1);

    logic chk_q;
    logic way_end;

    // A way is finished by its tag (no data check) or by its last entry.
    assign way_end = take & (phase_data ? (ent == LAST_ENT) : !chk_q);

    // Advance the way, entry and type position on each accepted item.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; done <= 1'b0; phase_data <= 1'b0;
            way <= '0; ent <= '0; chk_q <= 1'b0;
        end else if (start) begin
            busy <= 1'b1; done <= 1'b0; phase_data <= 1'b0;
            way <= '0; ent <= '0; chk_q <= chk_data;
        end else begin
            done <= 1'b0;
            if (take && !phase_data && chk_q) begin
                phase_data <= 1'b1;
                ent        <= '0;
            end else if (take && phase_data && !way_end) begin
                ent <= ent + 1'b1;
            end
            if (way_end) begin
                phase_data <= 1'b0;
                ent        <= '0;
                if (way == LAST_WAY) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    way <= way + 1'b1;
                end
            end
        end
    end

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r8_data_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase_data) |-> chk_q);
    a_r9_entry_zero_on_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !phase_data) |-> (ent == '0));
endmodule

// File: rtl/icache_parity_scrubber.sv
// Top: scans one instruction-cache set. It feeds tag and data items to the
// checkers, keeps sticky parity flags and the way-0 replacement order, and
// outputs the address of the next expected item. Assumes items are held
// for one cycle with item_valid.
module icache_parity_scrubber
    import icps_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int ENTRIES  = 4,
    parameter int IDX_W    = 8,
    parameter int HI_W     = 32,
    parameter int LO_W     = 64
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    scan_start,
    input  logic                                    scan_data_en,
    input  logic [IDX_W-1:0]                        scan_index,
    input  logic                                    item_valid,
    input  logic                                    item_is_data,
    input  logic [HI_W-1:0]                         item_hi,
    input  logic [LO_W-1:0]                         item_lo,
    output logic                                    scan_busy,
    output logic                                    scan_done,
    output logic                                    tag_parity_err,
    output logic                                    data_parity_err,
    output logic [NUM_WAYS*$clog2(NUM_WAYS)-1:0]    lru_order,
    output logic [$clog2(NUM_WAYS)-1:0]             lru_way,
    output logic [$clog2(NUM_WAYS)-1:0]             mru_way,
    output logic [$clog2(NUM_WAYS)+IDX_W+$clog2(ENTRIES)+2:0] next_addr,
    output logic                                    next_is_data,
    output logic [1:0]                              scan_bank,
    output logic [IDX_W-3:0]                        scan_set
);
    localparam int WAY_W   = $clog2(NUM_WAYS);
    localparam int ENT_W   = $clog2(ENTRIES);
    localparam int ORDER_W = NUM_WAYS * WAY_W;
    localparam int INSN_W  = LO_W / 2;

    logic             take;
    logic             tag_bad;
    logic             data_bad;
    logic             phase_data;
    logic [WAY_W-1:0] way;
    logic [ENT_W-1:0] ent;
    logic [IDX_W-1:0] idx_q;

    assign take = scan_busy & item_valid & (item_is_data == phase_data) & !scan_start;

    icps_seq #(.NUM_WAYS(NUM_WAYS), .ENTRIES(ENTRIES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(scan_start), .chk_data(scan_data_en),
        .take(take), .busy(scan_busy), .done(scan_done), .phase_data(phase_data),
        .way(way), .ent(ent)
    );

    icps_tag_check #(.HI_W(HI_W), .LO_W(LO_W)) u_tag (
        .tag_hi(item_hi), .tag_lo(item_lo), .tag_bad(tag_bad)
    );

    icps_data_check #(.SB_W(HI_W), .INSN_W(INSN_W)) u_data (
        .sideband(item_hi), .insn_a(item_lo[LO_W-1:INSN_W]),
        .insn_b(item_lo[INSN_W-1:0]), .data_bad(data_bad)
    );

    // Sticky flags, latched index and way-0 order; a start clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_parity_err  <= 1'b0;
            data_parity_err <= 1'b0;
            lru_order       <= '0;
            idx_q           <= '0;
        end else if (scan_start) begin
            tag_parity_err  <= 1'b0;
            data_parity_err <= 1'b0;
            lru_order       <= '0;
            idx_q           <= scan_index;
        end else if (take) begin
            if (item_is_data == ITEM_DATA) begin
                data_parity_err <= data_parity_err | data_bad;
            end else begin
                tag_parity_err <= tag_parity_err | tag_bad;
                if (way == '0) lru_order <= item_hi[LRU_LSB +: ORDER_W];
            end
        end
    end

    assign lru_way      = lru_order[WAY_W-1:0];
    assign mru_way      = lru_order[ORDER_W-1 -: WAY_W];
    assign next_addr    = {way, idx_q, ent, 3'b000};
    assign next_is_data = phase_data;
    assign scan_bank    = idx_q[1:0];
    assign scan_set     = idx_q[IDX_W-1:2];

    a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        scan_start |=> (!tag_parity_err && !data_parity_err && scan_busy));
    a_r10_tag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_parity_err && !scan_start) |=> tag_parity_err);
    a_r10_data_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (data_parity_err && !scan_start) |=> data_parity_err);
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_busy && !scan_start) |=>
            ($stable(tag_parity_err) && $stable(data_parity_err) && $stable(lru_order)));
    a_r7_order_way0_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_start && !(take && !item_is_data && way == '0)) |=> $stable(lru_order));
endmodule

// File: tb/tb_icache_parity_scrubber.sv
module tb_icache_parity_scrubber;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_start = 1'b0;
    logic        scan_data_en = 1'b0;
    logic [7:0]  scan_index = '0;
    logic        item_valid = 1'b0;
    logic        item_is_data = 1'b0;
    logic [31:0] item_hi = '0;
    logic [63:0] item_lo = '0;
    logic        scan_busy, scan_done, tag_parity_err, data_parity_err, next_is_data;
    logic [7:0]  lru_order;
    logic [1:0]  lru_way, mru_way, scan_bank;
    logic [14:0] next_addr;
    logic [5:0]  scan_set;

    int checks = 0;
    int errors = 0;

    logic [31:0] thi [4];
    logic [63:0] tlo [4];
    logic [31:0] sbw [4][4];
    logic [63:0] ins [4][4];

    always #2 clk = ~clk;

    icache_parity_scrubber dut (
        .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .scan_data_en(scan_data_en),
        .scan_index(scan_index), .item_valid(item_valid), .item_is_data(item_is_data),
        .item_hi(item_hi), .item_lo(item_lo), .scan_busy(scan_busy), .scan_done(scan_done),
        .tag_parity_err(tag_parity_err), .data_parity_err(data_parity_err),
        .lru_order(lru_order), .lru_way(lru_way), .mru_way(mru_way),
        .next_addr(next_addr), .next_is_data(next_is_data),
        .scan_bank(scan_bank), .scan_set(scan_set)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit ref_tag_bad(input logic [31:0] hi, input logic [63:0] lo);
        bit bad = (hi[29] != hi[27]);
        bit p0 = 0;
        bit p1 = 0;
        if (hi[29]) begin
            for (int i = 0; i < 24; i++) if (i != 10 && i != 11) p0 ^= lo[i];
            for (int i = 24; i < 64; i++) p1 ^= lo[i];
            if (p0 != lo[10] || p1 != lo[11]) bad = 1;
        end
        return bad;
    endfunction

    function automatic logic [3:0] byte_par(input logic [31:0] w);
        logic [3:0] p;
        for (int k = 0; k < 4; k++) p[k] = ^w[8*k +: 8];
        return p;
    endfunction

    function automatic bit ref_data_bad(input logic [31:0] sb, input logic [63:0] lo);
        bit bad = (sb[16] != ^sb[15:8]);
        if (sb[7:4] != byte_par(lo[63:32])) bad = 1;
        if (sb[3:0] != byte_par(lo[31:0])) bad = 1;
        return bad;
    endfunction

    function automatic logic [63:0] fix_lo(input logic [63:0] lo);
        logic [63:0] r = lo;
        r[11:10] = 2'b00;
        r[10] = ^r[23:0];
        r[11] = ^r[63:24];
        return r;
    endfunction

    function automatic logic [31:0] fix_sb(input logic [31:0] sb, input logic [63:0] lo);
        logic [31:0] r = sb;
        r[16] = ^r[15:8];
        r[7:4] = byte_par(lo[63:32]);
        r[3:0] = byte_par(lo[31:0]);
        return r;
    endfunction

    task automatic build_clean();
        for (int w = 0; w < 4; w++) begin
            thi[w] = $urandom;
            thi[w][27] = thi[w][29];
            tlo[w] = fix_lo({$urandom, $urandom});
            for (int e = 0; e < 4; e++) begin
                ins[w][e] = {$urandom, $urandom};
                sbw[w][e] = fix_sb($urandom, ins[w][e]);
            end
        end
    endtask

    task automatic send(input bit is_data, input logic [31:0] hi, input logic [63:0] lo);
        item_valid = 1'b1; item_is_data = is_data; item_hi = hi; item_lo = lo;
        @(posedge clk); @(negedge clk);
        item_valid = 1'b0;
    endtask

    task automatic begin_scan(input bit dchk, input logic [7:0] idx);
        scan_start = 1'b1; scan_data_en = dchk; scan_index = idx;
        @(posedge clk); @(negedge clk);
        scan_start = 1'b0;
        chk(scan_busy && !tag_parity_err && !data_parity_err && !next_is_data, "R1 start state",
            {scan_busy, tag_parity_err, data_parity_err, next_is_data}, 4'b1000);
        chk(scan_bank == idx[1:0] && scan_set == idx[7:2], "R9 bank/set",
            {scan_set, scan_bank}, idx);
    endtask

    task automatic run_scan(input bit dchk, input logic [7:0] idx, input bit gaps);
        bit et = 0;
        bit ed = 0;
        begin_scan(dchk, idx);
        for (int w = 0; w < 4; w++) begin
            et |= ref_tag_bad(thi[w], tlo[w]);
            chk(next_addr == {w[1:0], idx, 2'b00, 3'b000} && !next_is_data, "R9 tag address",
                {next_is_data, next_addr}, {w[1:0], idx, 5'b0});
            chk(!scan_done, "R8 no early done", scan_done, 0);
            if (gaps && $urandom % 2) begin @(posedge clk); @(negedge clk); end
            send(0, thi[w], tlo[w]);
            if (dchk) for (int e = 0; e < 4; e++) begin
                ed |= ref_data_bad(sbw[w][e], ins[w][e]);
                chk(next_addr == {w[1:0], idx, e[1:0], 3'b000} && next_is_data, "R9 data address",
                    {next_is_data, next_addr}, {1'b1, w[1:0], idx, e[1:0], 3'b000});
                send(1, sbw[w][e], ins[w][e]);
            end
        end
        chk(scan_done && !scan_busy, "R8 done after last item", {scan_done, scan_busy}, 2'b10);
        chk(tag_parity_err == et, "R2 R3 R4 tag flag", tag_parity_err, et);
        chk(data_parity_err == ed, "R5 R6 data flag", data_parity_err, ed);
        chk(lru_order == thi[0][21:14] && lru_way == thi[0][15:14] && mru_way == thi[0][21:20],
            "R7 order from way 0", lru_order, thi[0][21:14]);
        @(posedge clk); @(negedge clk);
        chk(!scan_done, "R8 done is one cycle", scan_done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!scan_busy && !scan_done && !tag_parity_err && !data_parity_err && lru_order == 0,
            "R1 reset state", {scan_busy, scan_done, tag_parity_err, data_parity_err, lru_order}, 0);

        // Clean scans, with and without data checking.
        build_clean(); run_scan(1, 8'hA5, 0);
        build_clean(); run_scan(0, 8'h3C, 1);

        // R2: valid clear, copy set -> tag flag, even though the way is invalid.
        build_clean(); thi[2][29] = 0; thi[2][27] = 1; run_scan(0, 8'h11, 0);

        // R3/R4: an invalid way with broken low-tag fields is not flagged.
        build_clean(); thi[1][29] = 0; thi[1][27] = 0; tlo[1][10] ^= 1; tlo[1][11] ^= 1;
        run_scan(0, 8'h22, 0);
        chk(!tag_parity_err, "R3 R4 invalid way not checked", tag_parity_err, 0);

        // R3: valid way, bit 10 flipped.
        build_clean(); thi[3][29] = 1; thi[3][27] = 1; tlo[3][10] ^= 1; run_scan(0, 8'h33, 0);
        // R4: valid way, bit 40 flipped.
        build_clean(); thi[0][29] = 1; thi[0][27] = 1; tlo[0][40] ^= 1; run_scan(0, 8'h44, 0);

        // R5: predecode parity error.
        build_clean(); sbw[2][3][16] ^= 1; run_scan(1, 8'h55, 0);

        // R6: top byte of instruction A maps to sideband bit 7.
        build_clean(); ins[1][0] = 64'h0100_0000_0000_0000;
        sbw[1][0] = fix_sb(32'h0, ins[1][0]);
        chk(sbw[1][0][7:0] == 8'h80, "R6 top byte to top bit", sbw[1][0][7:0], 8'h80);
        run_scan(1, 8'h66, 0);
        chk(!data_parity_err, "R6 correct mapping passes", data_parity_err, 0);
        build_clean(); ins[1][0] = 64'h0100_0000_0000_0000;
        sbw[1][0] = fix_sb(32'h0, ins[1][0]); sbw[1][0][7:4] = 4'b0001;
        run_scan(1, 8'h67, 0);
        chk(data_parity_err, "R6 swapped mapping flagged", data_parity_err, 1);

        // R6: data errors are ignored when data checking is off.
        build_clean(); sbw[0][0][3] ^= 1;
        run_scan(0, 8'h68, 0);

        // R10: wrong-type item ignored, then stickiness after an early error.
        build_clean(); tlo[1][30] ^= 1; thi[1][29] = 1; thi[1][27] = 1;
        begin_scan(1, 8'h77);
        send(1, 32'h0001_0000, 64'h0);
        chk(next_addr == {2'b00, 8'h77, 5'b0} && !next_is_data && !data_parity_err,
            "R10 wrong type ignored", {data_parity_err, next_is_data, next_addr}, {2'b00, 8'h77, 5'b0});
        for (int w = 0; w < 4; w++) begin
            send(0, thi[w], tlo[w]);
            if (w == 1) chk(tag_parity_err, "R10 flag right after bad tag", tag_parity_err, 1);
            for (int e = 0; e < 4; e++) send(1, sbw[w][e], ins[w][e]);
        end
        chk(tag_parity_err && scan_done, "R10 flag still set at end", {tag_parity_err, scan_done}, 2'b11);
        @(negedge clk);

        // R10: items while idle are ignored.
        send(0, 32'h2000_0000, 64'hFFFF);
        send(1, 32'h0001_0000, 64'h1);
        chk(tag_parity_err && !data_parity_err && !scan_busy, "R10 idle items ignored",
            {tag_parity_err, data_parity_err, scan_busy}, 3'b100);

        // R1: restart during a scan clears the flags.
        build_clean(); thi[0][27] ^= 1;
        begin_scan(0, 8'h12);
        send(0, thi[0], tlo[0]);
        chk(tag_parity_err, "R2 flag before restart", tag_parity_err, 1);
        build_clean(); run_scan(0, 8'h13, 0);

        // Random scans with random single-bit faults.
        for (int n = 0; n < 24; n++) begin
            build_clean();
            for (int f = 0; f < int'($urandom % 3); f++) begin
                int w = $urandom % 4;
                int e = $urandom % 4;
                case ($urandom % 4)
                    0: thi[w][$urandom % 32] ^= 1;
                    1: tlo[w][$urandom % 64] ^= 1;
                    2: sbw[w][e][$urandom % 17] ^= 1;
                    default: ins[w][e][$urandom % 64] ^= 1;
                endcase
            end
            run_scan($urandom % 2, 8'($urandom), 1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule